// File: doc/BRIEF.md
# Byte ALU with Status Flag Update

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it can take two byte operands, a 5-bit operation code and the current status byte. One clock edge later it presents the result byte, a write-enable for the destination register and the new status byte. The arithmetic itself is combinational. The output stage is a single register, so a new request can be accepted on every cycle.

The status byte is eight bits wide. From bit 7 down to bit 0 the bits are: interrupt enable, transfer bit, half carry, sign, overflow, negative, zero and carry. The two top bits are never computed here; they are copied from the input. Every operation owns a fixed set of the six lower flags. It rewrites only that set, and every other flag is copied through unchanged. The carry-consuming operations take their carry-in from bit 0 of the incoming status byte. The borrow-chained subtract and compare take bit 1 of that byte as well, so that a zero test can span several bytes.

Top module: `alu8_status`

## Requirements
- R1: A request taken with `in_valid` high at a rising edge appears on `res_q`, `res_we_q` and `stat_q` right after that edge. `out_valid` is high for exactly that one cycle. Synchronous active-low reset clears all outputs to zero.
- R2: Status bit positions are, from 7 to 0: I, T, H, S, V, N, Z, C. Output bits 7 and 6 always equal input bits 7 and 6 of the request.
- R3: Codes 0 (add) and 1 (add plus C) produce the 8-bit sum. C is the carry out of bit 7, H is the carry out of bit 3 and V is signed overflow; N and Z follow the result. Only code 1 adds the incoming C.
- R4: Codes 2 (subtract), 3 (subtract minus C), 4 (compare) and 5 (compare minus C) produce the difference. C is the borrow out of bit 7, H is the borrow out of bit 3 and V is signed overflow. Codes 4 and 5 drive `res_q` with the difference but hold `res_we_q` low.
- R5: For codes 3 and 5, Z becomes 1 only if the difference is zero and the incoming Z is 1. These codes can clear Z but can never set it.
- R6: Codes 6 (AND), 7 (OR) and 8 (XOR) clear V, set N and Z from the result, and leave C and H unchanged.
- R7: Code 9 produces 0xFF minus A, sets C to 1, clears V and leaves H alone. Code 10 produces 0x00 minus A, sets C when A is nonzero, sets V when A is 0x80, and sets H when the low nibble of A is nonzero.
- R8: Code 11 (increment) and code 12 (decrement) set V only when A is 0x7F or 0x80 respectively, set N and Z, and leave C and H unchanged.
- R9: Codes 13 to 17 shift or rotate A. The codes are: 13 left shift with zero fill, 14 right shift with zero fill, 15 right shift keeping bit 7, 16 left rotate with C into bit 0, 17 right rotate with C into bit 7. C receives the bit shifted out, V equals N XOR C, and H is unchanged.
- R10: Code 18 swaps the two nibbles of A, writes the result and changes no flag.
- R11: For every code from 0 to 17, the new S equals the new N XOR the new V.
- R12: Codes 19 to 31 hold `res_we_q` low and pass the status byte through unchanged.
- R13: A cycle with `in_valid` low drives `out_valid` and `res_we_q` low, and `res_q` and `stat_q` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 5 | Operation code |
| opa | input | DATA_W | Operand A (also the operand of unary operations) |
| opb | input | DATA_W | Operand B |
| stat_in | input | 8 | Current status byte |
| out_valid | output | 1 | Result registered this cycle |
| res_q | output | DATA_W | Registered result |
| res_we_q | output | 1 | Destination write-enable |
| stat_q | output | 8 | Registered new status byte |

## Verification
The unary codes and the nibble swap are run with every byte value of A. This covers the boundary points 0x00, 0x7F, 0x80 and 0xFF, which separate the overflow, borrow and forced-carry rules. The two-operand codes pair every A with sixteen B values spread over the byte, which reaches both carry and no-carry at the nibble and at the byte boundary. The incoming status byte is varied so that both carry-in values and both incoming zero values appear. This separates carry-consuming codes from plain ones and separates the sticky zero from the ordinary zero. Untouched flags are seeded with mixed values, so a flag that is written when it should have been held shows up as a mismatch. Idle cycles between requests show that outputs hold.

// File: rtl/alu8_pkg.sv
// Package: operation codes, flag bit positions and the decode record
// shared by the ALU stages. Assumes an 8-bit status byte.
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_CMPC = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ROR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    localparam int STAT_W = 8;
    localparam int FLG_C  = 0;
    localparam int FLG_Z  = 1;
    localparam int FLG_N  = 2;
    localparam int FLG_V  = 3;
    localparam int FLG_S  = 4;
    localparam int FLG_H  = 5;
    localparam int NFLAGS = 6;

    // Flag ownership masks, indexed by flag position
    localparam logic [NFLAGS-1:0] MASK_ARITH = 6'b111111;
    localparam logic [NFLAGS-1:0] MASK_LOGIC = 6'b011110;
    localparam logic [NFLAGS-1:0] MASK_SHIFT = 6'b011111;
    localparam logic [NFLAGS-1:0] MASK_NONE  = 6'b000000;

    // Operand B source for the adder
    typedef enum logic [1:0] {
        BSRC_OPB = 2'd0,
        BSRC_OPA = 2'd1,
        BSRC_ONE = 2'd2
    } bsrc_e;

    typedef struct packed {
        logic              arith;     // result from adder path
        logic              sub;       // subtract instead of add
        logic              a_zero;    // adder operand A forced to zero
        bsrc_e             b_src;     // adder operand B source
        logic              use_cin;   // consume incoming carry
        logic              sticky_z;  // zero only kept, never set
        logic              shift_v;   // V = N xor C
        logic              write;     // destination write-enable
        logic [NFLAGS-1:0] mask;      // flags this operation owns
    } dec_t;

endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor: computes a+b+cin or a-b-cin, plus carry or borrow out
// of the top bit and of the low half, and signed overflow.
// Assumes DATA_W is even and at least 4.
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              hout,
    output logic              vout
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W:0] full;
    logic [HALF:0]   low;

    // Full-width and half-width add or subtract
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
        end
    end

    assign sum  = full[DATA_W-1:0];
    assign cout = full[DATA_W];
    assign hout = low[HALF];

    // Signed overflow from operand and result signs
    always_comb begin
        if (sub)
            vout = (a[MSB] != b[MSB]) && (sum[MSB] != a[MSB]);
        else
            vout = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu8_bitops.sv
// Bitwise, complement, shift, rotate and nibble-swap path.
// Assumes DATA_W is even; codes outside this path return A with carry 0.
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    // Select the bit-level result and the bit shifted out
    always_comb begin
        res  = a;
        cout = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM: begin
                res  = ~a;
                cout = 1'b1;
            end
            OP_LSL: begin
                res  = {a[MSB-1:0], 1'b0};
                cout = a[MSB];
            end
            OP_LSR: begin
                res  = {1'b0, a[MSB:1]};
                cout = a[0];
            end
            OP_ASR: begin
                res  = {a[MSB], a[MSB:1]};
                cout = a[0];
            end
            OP_ROL: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            OP_ROR: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
            OP_SWAP: res = {a[HALF-1:0], a[MSB:HALF]};
            default: begin
                res  = a;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_flagmerge.sv
// Builds the new status byte: derives N, Z, S from the result, then takes
// each of the six lower flags from the new value or the old byte by mask.
// I and T pass through.
module alu8_flagmerge
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              h_new,
    input  logic              v_new,
    input  logic              c_new,
    input  logic              sticky_z,
    input  logic [NFLAGS-1:0] mask,
    input  logic [STAT_W-1:0] stat_old,
    output logic [STAT_W-1:0] stat_new
);
    logic              n_new;
    logic              z_new;
    logic [NFLAGS-1:0] fresh;

    // Negative and zero from the result; sticky zero ANDs the old Z
    always_comb begin
        n_new = res[DATA_W-1];
        z_new = (res == '0) && (!sticky_z || stat_old[FLG_Z]);
    end

    // Assemble candidate flags in status order
    always_comb begin
        fresh        = '0;
        fresh[FLG_C] = c_new;
        fresh[FLG_Z] = z_new;
        fresh[FLG_N] = n_new;
        fresh[FLG_V] = v_new;
        fresh[FLG_S] = n_new ^ v_new;
        fresh[FLG_H] = h_new;
    end

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        assign stat_new[i] = mask[i] ? fresh[i] : stat_old[i];
    end
    assign stat_new[STAT_W-1:NFLAGS] = stat_old[STAT_W-1:NFLAGS];
endmodule

// File: rtl/alu8_status.sv
// Top: decodes the operation, runs the adder and bit-op paths, merges flags
// and registers result, write-enable and status once per valid request.
// Assumes stat_in carries the current status; one-cycle latency.
module alu8_status
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [STAT_W-1:0] stat_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_q,
    output logic              res_we_q,
    output logic [STAT_W-1:0] stat_q
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    dec_t              dec;
    logic [DATA_W-1:0] add_a, add_b, add_sum, bit_res, res;
    logic              add_cin, add_c, add_h, add_v, bit_c;
    logic              c_new, v_new;
    logic [STAT_W-1:0] stat_new;

    // Decode operation code into datapath controls
    always_comb begin
        dec = '{arith: 1'b0, sub: 1'b0, a_zero: 1'b0, b_src: BSRC_OPB,
                use_cin: 1'b0, sticky_z: 1'b0, shift_v: 1'b0,
                write: 1'b0, mask: MASK_NONE};
        case (op_sel)
            OP_ADD, OP_ADC: begin
                dec.arith   = 1'b1;
                dec.use_cin = (op_sel == OP_ADC);
                dec.write   = 1'b1;
                dec.mask    = MASK_ARITH;
            end
            OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
                dec.arith    = 1'b1;
                dec.sub      = 1'b1;
                dec.use_cin  = (op_sel == OP_SBC) || (op_sel == OP_CMPC);
                dec.sticky_z = dec.use_cin;
                dec.write    = (op_sel == OP_SUB) || (op_sel == OP_SBC);
                dec.mask     = MASK_ARITH;
            end
            OP_AND, OP_OR, OP_XOR: begin
                dec.write = 1'b1;
                dec.mask  = MASK_LOGIC;
            end
            OP_COM: begin
                dec.write = 1'b1;
                dec.mask  = MASK_SHIFT;
            end
            OP_NEG: begin
                dec.arith  = 1'b1;
                dec.sub    = 1'b1;
                dec.a_zero = 1'b1;
                dec.b_src  = BSRC_OPA;
                dec.write  = 1'b1;
                dec.mask   = MASK_ARITH;
            end
            OP_INC, OP_DEC: begin
                dec.arith = 1'b1;
                dec.sub   = (op_sel == OP_DEC);
                dec.b_src = BSRC_ONE;
                dec.write = 1'b1;
                dec.mask  = MASK_LOGIC;
            end
            OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
                dec.shift_v = 1'b1;
                dec.write   = 1'b1;
                dec.mask    = MASK_SHIFT;
            end
            OP_SWAP: begin
                dec.write = 1'b1;
                dec.mask  = MASK_NONE;
            end
            default: dec.write = 1'b0;
        endcase
    end

    // Adder operand selection
    always_comb begin
        add_a   = dec.a_zero ? '0 : opa;
        case (dec.b_src)
            BSRC_OPA: add_b = opa;
            BSRC_ONE: add_b = ONE;
            default:  add_b = opb;
        endcase
        add_cin = dec.use_cin & stat_in[FLG_C];
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_cin),
        .sub  (dec.sub),
        .sum  (add_sum),
        .cout (add_c),
        .hout (add_h),
        .vout (add_v)
    );

    alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op   (op_sel),
        .a    (opa),
        .b    (opb),
        .cin  (stat_in[FLG_C]),
        .res  (bit_res),
        .cout (bit_c)
    );

    // Choose result, carry and overflow between the two paths
    always_comb begin
        res   = dec.arith ? add_sum : bit_res;
        c_new = dec.arith ? add_c : bit_c;
        if (dec.arith)
            v_new = add_v;
        else if (dec.shift_v)
            v_new = bit_res[MSB] ^ bit_c;
        else
            v_new = 1'b0;
    end

    alu8_flagmerge #(.DATA_W(DATA_W)) u_flags (
        .res      (res),
        .h_new    (add_h),
        .v_new    (v_new),
        .c_new    (c_new),
        .sticky_z (dec.sticky_z),
        .mask     (dec.mask),
        .stat_old (stat_in),
        .stat_new (stat_new)
    );

    // Output register: capture on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_we_q  <= 1'b0;
            res_q     <= '0;
            stat_q    <= '0;
        end else begin
            out_valid <= in_valid;
            res_we_q  <= in_valid & dec.write;
            if (in_valid) begin
                res_q  <= res;
                stat_q <= stat_new;
            end
        end
    end
endmodule

// File: rtl/alu8_status_chk.sv
// Checker: temporal properties of the ALU ports, bound to alu8_status.
module alu8_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [4:0]        op_sel,
    input logic [DATA_W-1:0] opa,
    input logic [7:0]        stat_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] res_q,
    input logic              res_we_q,
    input logic [7:0]        stat_q
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !res_we_q && $stable(res_q) && $stable(stat_q)));

    a_r2_it_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (stat_q[7:6] == $past(stat_in[7:6])));

    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 5'd4 || op_sel == 5'd5)) |=> !res_we_q);

    a_r5_sticky_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 5'd3 || op_sel == 5'd5) && !stat_in[1]) |=> !stat_q[1]);

    a_r6_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 5'd6 && op_sel <= 5'd8)
        |=> (!stat_q[3] && stat_q[0] == $past(stat_in[0]) && stat_q[5] == $past(stat_in[5])));

    a_r7_com_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 5'd9) |=> (stat_q[0] && res_q == ~$past(opa)));

    a_r10_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 5'd18) |=> (stat_q[5:0] == $past(stat_in[5:0]) && res_we_q));

    a_r11_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel <= 5'd17) |=> (stat_q[4] == (stat_q[2] ^ stat_q[3])));

    a_r12_undef_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 5'd19) |=> (!res_we_q && stat_q == $past(stat_in)));
endmodule

bind alu8_status alu8_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .opa       (opa),
    .stat_in   (stat_in),
    .out_valid (out_valid),
    .res_q     (res_q),
    .res_we_q  (res_we_q),
    .stat_q    (stat_q)
);

// File: tb/test_alu8_status.sv
// Bench: sweeps every operation over all A values (and spread B values)
// against an integer model written from the requirements.
module test_alu8_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] opa = '0, opb = '0, stat_in = '0;
    logic       out_valid, res_we_q;
    logic [7:0] res_q, stat_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alu8_status #(.DATA_W(8)) i_alu8_status (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .stat_in(stat_in), .out_valid(out_valid),
        .res_q(res_q), .res_we_q(res_we_q), .stat_q(stat_q)
    );

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic string tag_of(input int op);
        if (op <= 1)  return "R3";
        if (op <= 5)  return "R4/R5";
        if (op <= 8)  return "R6";
        if (op <= 10) return "R7";
        if (op <= 12) return "R8";
        if (op <= 17) return "R9";
        if (op == 18) return "R10";
        return "R12";
    endfunction

    // Reference model: integer arithmetic from the requirement text
    function automatic void model(input int op, input int a, input int b, input int st,
                                  output int res, output int we, output int so);
        int cf, zf, h, v, c, n, z, s, mask, t, ss;
        cf = st & 1; zf = (st >> 1) & 1;
        h = 0; v = 0; c = 0; mask = 0; we = 1; res = a;
        case (op)
            0, 1: begin
                t = a + b + ((op == 1) ? cf : 0);
                res = t & 255; c = (t > 255);
                h = (((a & 15) + (b & 15) + ((op == 1) ? cf : 0)) > 15);
                ss = sgn(a) + sgn(b) + ((op == 1) ? cf : 0);
                v = (ss > 127 || ss < -128); mask = 63;
            end
            2, 3, 4, 5: begin
                t = a - b - ((op == 3 || op == 5) ? cf : 0);
                res = t & 255; c = (t < 0);
                h = (((a & 15) - (b & 15) - ((op == 3 || op == 5) ? cf : 0)) < 0);
                ss = sgn(a) - sgn(b) - ((op == 3 || op == 5) ? cf : 0);
                v = (ss > 127 || ss < -128); mask = 63; we = (op < 4);
            end
            6: begin res = a & b; mask = 30; end
            7: begin res = a | b; mask = 30; end
            8: begin res = a ^ b; mask = 30; end
            9: begin res = 255 - a; c = 1; mask = 31; end
            10: begin res = (256 - a) & 255; c = (a != 0); v = (a == 128);
                      h = ((a & 15) != 0); mask = 63; end
            11: begin res = (a + 1) & 255; v = (a == 127); mask = 30; end
            12: begin res = (a + 255) & 255; v = (a == 128); mask = 30; end
            13: begin res = (a * 2) & 255; c = (a >= 128); mask = 31; end
            14: begin res = a / 2; c = a & 1; mask = 31; end
            15: begin res = a / 2 + (a & 128); c = a & 1; mask = 31; end
            16: begin res = ((a * 2) & 255) + cf; c = (a >= 128); mask = 31; end
            17: begin res = a / 2 + cf * 128; c = a & 1; mask = 31; end
            18: begin res = (a % 16) * 16 + a / 16; mask = 0; end
            default: begin we = 0; mask = 0; end
        endcase
        n = res / 128;
        if (op >= 13 && op <= 17) v = n ^ c;
        s = n ^ v;
        z = (res == 0) ? 1 : 0;
        if (op == 3 || op == 5) z = z & zf;
        so = st;
        if (mask & 1)  so = (so & ~1)  | c;
        if (mask & 2)  so = (so & ~2)  | (z << 1);
        if (mask & 4)  so = (so & ~4)  | (n << 2);
        if (mask & 8)  so = (so & ~8)  | (v << 3);
        if (mask & 16) so = (so & ~16) | (s << 4);
        if (mask & 32) so = (so & ~32) | (h << 5);
    endfunction

    int last_res = 0, last_st = 0;

    // Drive one request at a falling edge, check at the next falling edge
    task automatic run_vec(input int op, input int a, input int b, input int st);
        int er, ew, es;
        bit bad;
        op_sel = op[4:0]; opa = a[7:0]; opb = b[7:0]; stat_in = st[7:0]; in_valid = 1'b1;
        model(op, a, b, st, er, ew, es);
        @(negedge clk);
        checks++;
        bad = (out_valid !== 1'b1) || (res_we_q !== ew[0]) || (stat_q !== es[7:0]) ||
              ((op <= 18) && (res_q !== er[7:0]));
        if (bad) begin
            errors++;
            $display("FAIL %s (R1 R2 R11) op=%0d a=%02h b=%02h st=%02h: got v=%0d res=%02h we=%0d st=%02h, exp v=1 res=%02h we=%0d st=%02h",
                     tag_of(op), op, a, b, st, out_valid, res_q, res_we_q, stat_q, er, ew, es);
        end
        last_res = res_q; last_st = stat_q;
    endtask

    // Idle cycle: outputs must hold and strobes drop
    task automatic idle_check();
        in_valid = 1'b0; opa = 8'h5A; stat_in = 8'hA5; op_sel = 5'd0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || res_we_q !== 1'b0 || res_q !== last_res[7:0] || stat_q !== last_st[7:0]) begin
            errors++;
            $display("FAIL R13 idle: got v=%0d we=%0d res=%02h st=%02h, exp v=0 we=0 res=%02h st=%02h",
                     out_valid, res_we_q, res_q, stat_q, last_res, last_st);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || res_we_q !== 1'b0 || res_q !== 8'h00 || stat_q !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset: got v=%0d we=%0d res=%02h st=%02h, exp 0 0 00 00",
                     out_valid, res_we_q, res_q, stat_q);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // Two-operand codes: every A, sixteen B values, varied status
        for (int op = 0; op <= 8; op++) begin
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++)
                    for (int k = 0; k < 2; k++)
                        run_vec(op, a, bi * 17, ((a * 29 + bi * 11 + k * 53) & 252) | ((a + bi + k * 2) & 3));
            idle_check();
        end
        // Unary codes and swap: every A, all four C/Z combinations
        for (int op = 9; op <= 18; op++) begin
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 4; k++)
                    run_vec(op, a, 255 - a, ((a * 37 + k * 71 + op) & 252) | k);
            idle_check();
        end
        // Undefined codes
        for (int op = 19; op < 32; op++)
            for (int k = 0; k < 4; k++)
                run_vec(op, k * 60 + 3, k * 9, (op * 23 + k * 101) & 255);
        idle_check();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule